// File: doc/BRIEF.md
# Horizontal Pairwise Add/Subtract Unit

This block reduces neighbouring element pairs inside each of two 128-bit packed operands and packs the pair results into a single 128-bit word. The pair results taken from operand A occupy the low half of the output. The pair results taken from operand B occupy the high half. Elements are either 16 or 32 bits wide, and a pair is combined by addition or by subtraction. For 16-bit elements the caller chooses between wrap-around arithmetic and signed saturation.

One operation is accepted per cycle, marked by an input valid strobe. The result is registered and appears with its own valid flag one clock later. A synchronous reset clears the output registers.

Top module: `hpaddsub_unit`

## Requirements
- R1: With `size_wide`=0, each operand holds eight 16-bit elements, element i in bits [16i+15:16i]. Output lane k (bits [16k+15:16k]) is the pair result of elements 2k and 2k+1 of `src_a` for k=0..3, and of elements 2(k-4) and 2(k-4)+1 of `src_b` for k=4..7. With `op_sub`=0 the pair result is the sum.
- R2: With `op_sub`=1 each pair result is the lower-indexed element minus the higher-indexed element. For example, 1 and 2 give -1.
- R3: With 16-bit elements, `sat_en`=1 and addition, a sum above 32767 becomes 0x7FFF and a sum below -32768 becomes 0x8000.
- R4: With 16-bit elements, `sat_en`=1 and subtraction, differences are clamped to the same bounds. 32767-(-1) gives 0x7FFF and -32768-1 gives 0x8000.
- R5: With `sat_en`=0, 16-bit results wrap modulo 2^16. For example, 32767+1 gives 0x8000.
- R6: With `size_wide`=1, each operand holds four 32-bit elements. The output is, low to high: A0∘A1, A2∘A3, B0∘B1, B2∘B3. Results wrap modulo 2^32.
- R7: `sat_en` has no effect when `size_wide`=1. 32-bit results always wrap.
- R8: `out_valid` equals `in_valid` of the previous cycle. `out_data` loads only in a cycle where `in_valid` is high, and holds its value otherwise.
- R9: While `rst` is high at a clock edge, `out_valid` and `out_data` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src_a | input | 128 | First operand, supplies the low output half |
| src_b | input | 128 | Second operand, supplies the high output half |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| size_wide | input | 1 | 0 selects 16-bit elements, 1 selects 32-bit elements |
| sat_en | input | 1 | Signed saturation for 16-bit elements |
| out_valid | output | 1 | Result present |
| out_data | output | 128 | Registered packed result |

## Verification
Operands with a distinct value in every element show whether each lane draws on the correct pair and the correct operand half. A layout error, such as swapped halves or an off-by-one pair, appears as a wrong lane. The same operands are then run through subtraction to check the operand order within each pair. Pairs placed at the signed limits are run both with and without saturation, which separates clamping from wrap-around. They are also run with 32-bit elements, to show that 32-bit results wrap even when saturation is requested. Idle cycles, back-to-back operations and a reset in the middle of the run check the valid timing and that the result holds between operations.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

  // Outcome of one pair operation
  typedef enum logic [1:0] {
    PAIR_PASS     = 2'b00,
    PAIR_CLAMP_HI = 2'b01,
    PAIR_CLAMP_LO = 2'b10
  } pair_flag_t;

  localparam int unsigned DEF_DATA_W = 128;
  localparam int unsigned DEF_HALF_W = 16;
  localparam int unsigned DEF_WORD_W = 32;

endpackage

// File: rtl/hpa_pair.sv
module hpa_pair
  import hpa_pkg::*;
#(
  parameter int unsigned EW     = 16,
  parameter bit          SAT_OK = 1'b1
) (
  input  logic [EW-1:0] x,
  input  logic [EW-1:0] y,
  input  logic          sub,
  input  logic          sat,
  output logic [EW-1:0] res,
  output logic          clamp_hi,
  output logic          clamp_lo
);

  localparam logic [EW-1:0] MAX_POS = {1'b0, {(EW-1){1'b1}}};
  localparam logic [EW-1:0] MIN_NEG = {1'b1, {(EW-1){1'b0}}};

  // Sign-extended add or subtract, one guard bit
  function automatic logic [EW:0] wide_op(input logic [EW-1:0] p,
                                          input logic [EW-1:0] q,
                                          input logic          do_sub);
    logic [EW:0] pe;
    logic [EW:0] qe;
    pe = {p[EW-1], p};
    qe = {q[EW-1], q};
    return do_sub ? (pe - qe) : (pe + qe);
  endfunction

  // Classify the guarded result
  function automatic pair_flag_t classify(input logic [EW:0] v, input logic en);
    if (en && !v[EW] && v[EW-1]) return PAIR_CLAMP_HI;
    if (en && v[EW] && !v[EW-1]) return PAIR_CLAMP_LO;
    return PAIR_PASS;
  endfunction

  logic [EW:0] full;
  logic        sat_eff;
  pair_flag_t  flag;

  assign sat_eff = sat && SAT_OK;
  assign full    = wide_op(x, y, sub);
  assign flag    = classify(full, sat_eff);

  assign clamp_hi = (flag == PAIR_CLAMP_HI);
  assign clamp_lo = (flag == PAIR_CLAMP_LO);

  always_comb begin
    unique case (flag)
      PAIR_CLAMP_HI: res = MAX_POS;
      PAIR_CLAMP_LO: res = MIN_NEG;
      default:       res = full[EW-1:0];
    endcase
  end

endmodule

// File: rtl/hpa_lanes.sv
module hpa_lanes #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned EW     = 16,
  parameter bit          SAT_OK = 1'b1
) (
  input  logic [2*DATA_W-1:0]  cat,
  input  logic                 sub,
  input  logic                 sat,
  output logic [DATA_W-1:0]    res,
  output logic [DATA_W/EW-1:0] clamp_hi,
  output logic [DATA_W/EW-1:0] clamp_lo
);

  localparam int unsigned NOUT = DATA_W / EW;

  // Output lane k combines elements 2k and 2k+1 of {src_b, src_a}
  for (genvar k = 0; k < NOUT; k++) begin : g_lane
    hpa_pair #(.EW(EW), .SAT_OK(SAT_OK)) u_pair (
      .x        (cat[(2*k)*EW   +: EW]),
      .y        (cat[(2*k+1)*EW +: EW]),
      .sub      (sub),
      .sat      (sat),
      .res      (res[k*EW +: EW]),
      .clamp_hi (clamp_hi[k]),
      .clamp_lo (clamp_lo[k])
    );
  end

endmodule

// File: rtl/hpaddsub_unit.sv
module hpaddsub_unit #(
  parameter int unsigned DATA_W = hpa_pkg::DEF_DATA_W,
  parameter int unsigned HALF_W = hpa_pkg::DEF_HALF_W,
  parameter int unsigned WORD_W = hpa_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              op_sub,
  input  logic              size_wide,
  input  logic              sat_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int unsigned N_HALF = DATA_W / HALF_W;
  localparam int unsigned N_WORD = DATA_W / WORD_W;

  logic [2*DATA_W-1:0] cat;
  logic [DATA_W-1:0]   half_res;
  logic [DATA_W-1:0]   word_res;
  logic [DATA_W-1:0]   next_data;
  logic [N_HALF-1:0]   half_clamp_hi;
  logic [N_HALF-1:0]   half_clamp_lo;
  logic [N_WORD-1:0]   word_clamp_hi;
  logic [N_WORD-1:0]   word_clamp_lo;
  logic                load_en;

  assign cat = {src_b, src_a};

  hpa_lanes #(.DATA_W(DATA_W), .EW(HALF_W), .SAT_OK(1'b1)) u_half (
    .cat      (cat),
    .sub      (op_sub),
    .sat      (sat_en),
    .res      (half_res),
    .clamp_hi (half_clamp_hi),
    .clamp_lo (half_clamp_lo)
  );

  hpa_lanes #(.DATA_W(DATA_W), .EW(WORD_W), .SAT_OK(1'b0)) u_word (
    .cat      (cat),
    .sub      (op_sub),
    .sat      (sat_en),
    .res      (word_res),
    .clamp_hi (word_clamp_hi),
    .clamp_lo (word_clamp_lo)
  );

  assign next_data = size_wide ? word_res : half_res;
  assign load_en   = in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (load_en) out_data <= next_data;
    end
  end

endmodule

// File: rtl/hpa_sva.sv
module hpa_sva #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned WORD_W = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [DATA_W-1:0]      src_a,
  input logic                   op_sub,
  input logic                   size_wide,
  input logic                   sat_en,
  input logic                   out_valid,
  input logic [DATA_W-1:0]      out_data,
  input logic [DATA_W/HALF_W-1:0] half_clamp_hi,
  input logic [DATA_W/HALF_W-1:0] half_clamp_lo,
  input logic [DATA_W/WORD_W-1:0] word_clamp_hi,
  input logic [DATA_W/WORD_W-1:0] word_clamp_lo
);

  localparam int unsigned N_HALF = DATA_W / HALF_W;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));  // R9

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));  // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(out_data));  // R8

  AST_LANE0_SUM: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !size_wide && !op_sub && !sat_en) |=>
      (out_data[HALF_W-1:0] == $past(src_a[HALF_W-1:0] + src_a[2*HALF_W-1:HALF_W])));  // R1

  AST_NO_CLAMP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_en) |-> (half_clamp_hi == '0 && half_clamp_lo == '0));  // R5

  AST_WIDE_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_wide && !op_sub) |=>
      (out_data[WORD_W-1:0] == $past(src_a[WORD_W-1:0] + src_a[2*WORD_W-1:WORD_W])));  // R7

  AST_WIDE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (word_clamp_hi == '0 && word_clamp_lo == '0));  // R7

  for (genvar k = 0; k < N_HALF; k++) begin : g_sat
    AST_CLAMP_EXCL: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> !(half_clamp_hi[k] && half_clamp_lo[k]));  // R3
    AST_CLAMP_MAX: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !size_wide && half_clamp_hi[k]) |=>
        (out_data[k*HALF_W +: HALF_W] == {1'b0, {(HALF_W-1){1'b1}}}));  // R3
    AST_CLAMP_MIN: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !size_wide && half_clamp_lo[k]) |=>
        (out_data[k*HALF_W +: HALF_W] == {1'b1, {(HALF_W-1){1'b0}}}));  // R4
  end

endmodule

bind hpaddsub_unit hpa_sva #(.DATA_W(DATA_W), .HALF_W(HALF_W), .WORD_W(WORD_W)) u_sva (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .src_a         (src_a),
  .op_sub        (op_sub),
  .size_wide     (size_wide),
  .sat_en        (sat_en),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .half_clamp_hi (half_clamp_hi),
  .half_clamp_lo (half_clamp_lo),
  .word_clamp_hi (word_clamp_hi),
  .word_clamp_lo (word_clamp_lo)
);

// File: tb/hpaddsub_unit_bench.sv
module hpaddsub_unit_bench;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] src_a;
  logic [127:0] src_b;
  logic         op_sub;
  logic         size_wide;
  logic         sat_en;
  logic         out_valid;
  logic [127:0] out_data;

  int checks   = 0;
  int failures = 0;

  logic         exp_valid;
  logic [127:0] exp_data;
  string        exp_tag;

  always #2 clk = ~clk;  // 250 MHz

  hpaddsub_unit u_hpaddsub_unit (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .src_b     (src_b),
    .op_sub    (op_sub),
    .size_wide (size_wide),
    .sat_en    (sat_en),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [127:0] v16(input int e[8]);
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[16*i +: 16] = e[i][15:0];
    return v;
  endfunction

  function automatic logic [127:0] v32(input int e[4]);
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[32*i +: 32] = e[i];
    return v;
  endfunction

  // Behavioural model built from the requirements
  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input bit sub, input bit wide, input bit sat);
    logic [127:0] r;
    logic [127:0] src;
    longint x, y, s;
    r = '0;
    if (!wide) begin
      for (int k = 0; k < 8; k++) begin
        src = (k < 4) ? a : b;
        x = longint'($signed(src[32*(k%4) +: 16]));
        y = longint'($signed(src[32*(k%4)+16 +: 16]));
        s = sub ? x - y : x + y;
        if (sat && s > 32767)  s = 32767;
        if (sat && s < -32768) s = -32768;
        r[16*k +: 16] = s[15:0];
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        src = (k < 2) ? a : b;
        x = longint'($signed(src[64*(k%2) +: 32]));
        y = longint'($signed(src[64*(k%2)+32 +: 32]));
        s = sub ? x - y : x + y;
        r[32*k +: 32] = s[31:0];
      end
    end
    return r;
  endfunction

  task automatic compare_now();
    checks++;
    if (out_valid !== exp_valid) begin
      failures++;
      $display("FAIL %s out_valid actual=%0b expected=%0b", exp_tag, out_valid, exp_valid);
    end
    checks++;
    if (out_data !== exp_data) begin
      failures++;
      $display("FAIL %s out_data actual=%h expected=%h", exp_tag, out_data, exp_data);
    end
  endtask

  task automatic step(input logic [127:0] a, input logic [127:0] b, input bit sub,
                      input bit wide, input bit sat, input bit vld, input string tag);
    @(negedge clk);
    compare_now();
    src_a = a; src_b = b; op_sub = sub; size_wide = wide; sat_en = sat; in_valid = vld;
    exp_valid = vld;
    if (vld) exp_data = model(a, b, sub, wide, sat);
    exp_tag = tag;
  endtask

  task automatic reset_pulse();
    @(negedge clk);
    compare_now();
    rst = 1'b1; in_valid = 1'b1;
    src_a = {4{32'h1234_5678}}; src_b = src_a;
    exp_valid = 1'b0; exp_data = '0; exp_tag = "R9";
    @(negedge clk);
    compare_now();
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] a1, b1, a2, b2, a3, b3, w1, w2;
    rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0;
    op_sub = 1'b0; size_wide = 1'b0; sat_en = 1'b0;
    exp_valid = 1'b0; exp_data = '0; exp_tag = "R9";
    repeat (3) @(negedge clk);
    compare_now();  // R9 reset state
    rst = 1'b0;

    a1 = v16('{10, 3, 200, -50, 7, 9, -1000, 999});
    b1 = v16('{1, 2, 30000, 40, -5, -6, 123, 321});
    // Limits: 32767+1, -32768+(-1), 32767-(-1), -32768-1 arranged per pair
    a2 = v16('{32767, 1, -32768, -1, 100, 200, 0, 0});
    b2 = v16('{-32768, -32768, 32767, 32767, 5, -5, 30000, 30000});
    a3 = v16('{32767, -1, -32768, 1, 9, 4, -20000, 20000});
    b3 = v16('{20000, -20000, 1, 2, 0, 0, 7, 7});
    w1 = v32('{32'h7FFF_FFFF, 1, -5, 17});
    w2 = v32('{32'h8000_0000, 1, 1000, 2000});

    step(a1, b1, 0, 0, 0, 1, "R1");
    step(a1, b1, 1, 0, 0, 1, "R2");
    step(a2, b2, 0, 0, 1, 1, "R3");
    step(a3, b3, 1, 0, 1, 1, "R4");
    step(a2, b2, 0, 0, 0, 1, "R5");
    step(a3, b3, 1, 0, 0, 1, "R5");
    step(w1, w2, 0, 1, 0, 1, "R6");
    step(w1, w2, 1, 1, 0, 1, "R6");
    step(w1, w2, 0, 1, 1, 1, "R7");
    step(w2, w1, 1, 1, 1, 1, "R7");
    step('1, '1, 0, 0, 0, 0, "R8");       // idle: data must hold
    step(b1, a1, 0, 0, 1, 0, "R8");       // idle with changing inputs
    step(b1, a1, 1, 0, 0, 1, "R8");
    step(a2, a1, 0, 0, 1, 1, "R8");       // back to back
    reset_pulse();
    step(b3, a3, 0, 0, 1, 1, "R9");
    step('0, '0, 0, 0, 0, 0, "R8");
    @(negedge clk);
    compare_now();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule